// File: doc/BRIEF.md
# Paged Effective Address Generator

This block works out the operand address for a processor with a 15-bit address space. The space is divided into four pages of 8192 bytes, and the page is chosen by the two top bits. A request arrives with the program counter and the instruction's operand field. It also carries mode flags for relative or absolute, indirect, and an index mode, together with the current value of the selected index register. The block then returns the final effective address. Plain data accesses never leave the page that holds the program counter. An indirect access fetches a two-byte pointer, and that pointer may name any page.

An indirect request triggers two byte reads through a simple request/valid port, and each read may wait any number of cycles. An indexed request adds the register value last, after any indirection has finished. The register may first be stepped up or down, and in that case the block supplies the stepped value for write-back. The surrounding decode logic starts one request at a time and collects the result on a one-cycle valid pulse.

Top module: `paged_ea_gen`

## Requirements
- R1: While reset is asserted, and afterwards until a request is accepted, `busy_o`, `rd_req_o`, `ea_valid_o` and `idx_wr_o` are all low.
- R2: An absolute, non-indirect request (`rel_i`=0, `ind_i`=0) gives `ea_o` = {pc_i[14:13], operand_i[12:0]}, with `ea_valid_o` high for exactly the one cycle after the accepting clock edge.
- R3: A relative request treats operand_i[6:0] as a signed two's-complement displacement. It adds this to pc_i[12:0], where pc_i is the address of the byte after the instruction, and keeps the sum modulo 8192 within the page pc_i[14:13].
- R4: An indirect request raises `rd_req_o` with `rd_addr_o` equal to the base address from R2/R3 and reads the high pointer byte there. It then reads the low byte at the next offset, which wraps within the same page. Each address is held until `rd_valid_i` is seen high at a clock edge.
- R5: After an indirect fetch, the pre-index address is {high, low}[14:0], so it may lie in any page. `ea_valid_o` rises in the cycle after the second accepted read.
- R6: Index mode `idx_mode_i` is encoded as 0 = none, 1 = add, 2 = pre-increment, 3 = pre-decrement. The stepped register value (modulo 256) is the one added. The addition is unsigned and wraps modulo 8192 within the page of the pre-index address.
- R7: For modes 2 and 3, `idx_wr_o` pulses together with `ea_valid_o` and carries the stepped value on `idx_new_o`. For modes 0 and 1, `idx_wr_o` stays low.
- R8: When `dest_r0_i` is low, the index mode is ignored: `ea_o` equals the unindexed address and `idx_wr_o` stays low.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. The running request finishes with its own result, and only one `ea_valid_o` pulse follows.
- R10: `rd_valid_i` is ignored outside a pointer fetch. It neither starts nor shortens a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calculation (taken only when idle) |
| pc_i | input | 15 | Address of the byte after the instruction |
| operand_i | input | 13 | Operand address field; low 7 bits are the relative displacement |
| rel_i | input | 1 | 1 = relative, 0 = absolute |
| ind_i | input | 1 | 1 = indirect through a two-byte pointer |
| idx_mode_i | input | 2 | 0 none, 1 add, 2 pre-increment, 3 pre-decrement |
| dest_r0_i | input | 1 | Destination register is r0 (indexing permitted) |
| idx_val_i | input | 8 | Current value of the index register |
| rd_valid_i | input | 1 | Read data for the pending pointer byte is valid |
| rd_data_i | input | 8 | Pointer byte read from memory |
| busy_o | output | 1 | A request is in progress |
| rd_req_o | output | 1 | Pointer byte read request |
| rd_addr_o | output | 15 | Pointer byte address |
| ea_valid_o | output | 1 | One-cycle pulse: `ea_o` is the result |
| ea_o | output | 15 | Effective address |
| idx_wr_o | output | 1 | Write `idx_new_o` back to the index register |
| idx_new_o | output | 8 | Stepped index register value |

## Verification
The assertions run on every cycle and cover the handshake and sequencing rules. They check that all outputs stay quiet while idle, that a pending read address holds steady until the data is accepted, and that the low-byte address is one past the high-byte address within the same page. They also check that a result pulse lasts one cycle, drives no read, and carries any register write-back with it. Only the bench's scenarios can show that the addresses themselves are correct. These include page retention for absolute and relative forms, negative displacements that wrap across the page boundary, pointers that cross pages, and indexing applied after indirection. They also cover register stepping that wraps at 0 and 255, indexing suppressed for a non-r0 destination, and stray start or read-valid pulses that are ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_ADD  = 2'd1,
    IDX_INC  = 2'd2,
    IDX_DEC  = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PTR_HI = 2'd1,
    ST_PTR_LO = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/ea_base_calc.sv
// Page-local base address: absolute offset or PC-relative displacement.
module ea_base_calc #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 2,
  parameter int DISP_W = 7
) (
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [ADDR_W-PAGE_W-1:0] operand_i,
  input  logic                     rel_i,
  output logic [ADDR_W-1:0]        base_o
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  logic [OFF_W-1:0] disp_ext;
  logic [OFF_W-1:0] offset;

  always_comb begin
    disp_ext = {{(OFF_W-DISP_W){operand_i[DISP_W-1]}}, operand_i[DISP_W-1:0]};
    if (rel_i) begin
      offset = pc_i[OFF_W-1:0] + disp_ext;
    end else begin
      offset = operand_i;
    end
    base_o = {pc_i[ADDR_W-1:OFF_W], offset};
  end

endmodule

// File: rtl/ea_index_unit.sv
// Register stepping and page-wrapping index addition.
module ea_index_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 2,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] idx_val_i,
  input  idx_mode_e         mode_i,
  input  logic              allow_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [DATA_W-1:0] idx_new_o,
  output logic              idx_wr_o
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  logic             add_en;
  logic [OFF_W-1:0] off_sum;

  always_comb begin
    unique case (mode_i)
      IDX_INC: idx_new_o = idx_val_i + DATA_W'(1);
      IDX_DEC: idx_new_o = idx_val_i - DATA_W'(1);
      default: idx_new_o = idx_val_i;
    endcase
    add_en   = allow_i && (mode_i != IDX_NONE);
    idx_wr_o = allow_i && ((mode_i == IDX_INC) || (mode_i == IDX_DEC));
    off_sum  = base_i[OFF_W-1:0] + {{(OFF_W-DATA_W){1'b0}}, idx_new_o};
    if (add_en) begin
      ea_o = {base_i[ADDR_W-1:OFF_W], off_sum};
    end else begin
      ea_o = base_i;
    end
  end

endmodule

// File: rtl/ea_ptr_seq.sv
// Request sequencer: idle, two pointer byte reads, result cycle.
module ea_ptr_seq
  import ea_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ind_i,
  input  logic [ADDR_W-1:0] base_q_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  seq_state_e state_q, state_d;
  logic [DATA_W-1:0] hi_q, lo_q;
  logic hi_en, lo_en;
  logic [2*DATA_W-1:0] ptr_full;
  logic unused_ptr_bits;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ind_i ? ST_PTR_HI : ST_DONE;
      ST_PTR_HI: if (rd_valid_i) state_d = ST_PTR_LO;
      ST_PTR_LO: if (rd_valid_i) state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
    hi_en = (state_q == ST_PTR_HI) && rd_valid_i;
    lo_en = (state_q == ST_PTR_LO) && rd_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= rd_data_i;
      if (lo_en) lo_q <= rd_data_i;
    end
  end

  always_comb begin
    busy_o   = (state_q != ST_IDLE);
    done_o   = (state_q == ST_DONE);
    rd_req_o = (state_q == ST_PTR_HI) || (state_q == ST_PTR_LO);
    if (state_q == ST_PTR_LO) begin
      rd_addr_o = {base_q_i[ADDR_W-1:OFF_W], base_q_i[OFF_W-1:0] + OFF_W'(1)};
    end else begin
      rd_addr_o = base_q_i;
    end
    ptr_full = {hi_q, lo_q};
    ptr_o    = ptr_full[ADDR_W-1:0];
    unused_ptr_bits = ^ptr_full[2*DATA_W-1:ADDR_W];
  end

endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 2,
  parameter int DISP_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [ADDR_W-PAGE_W-1:0] operand_i,
  input  logic                     rel_i,
  input  logic                     ind_i,
  input  logic [1:0]               idx_mode_i,
  input  logic                     dest_r0_i,
  input  logic [DATA_W-1:0]        idx_val_i,
  input  logic                     rd_valid_i,
  input  logic [DATA_W-1:0]        rd_data_i,
  output logic                     busy_o,
  output logic                     rd_req_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     ea_valid_o,
  output logic [ADDR_W-1:0]        ea_o,
  output logic                     idx_wr_o,
  output logic [DATA_W-1:0]        idx_new_o
);

  logic              accept;
  logic [ADDR_W-1:0] base_d, base_q;
  logic [DATA_W-1:0] idx_q;
  idx_mode_e         mode_q;
  logic              allow_q, ind_q;
  logic              done;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] pre_idx;
  logic              wr_want;

  ea_base_calc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W)) u_base (
    .pc_i      (pc_i),
    .operand_i (operand_i),
    .rel_i     (rel_i),
    .base_o    (base_d)
  );

  assign accept = start_i && !busy_o;

  // Request context, captured once per accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      idx_q   <= '0;
      mode_q  <= IDX_NONE;
      allow_q <= 1'b0;
      ind_q   <= 1'b0;
    end else if (accept) begin
      base_q  <= base_d;
      idx_q   <= idx_val_i;
      mode_q  <= idx_mode_e'(idx_mode_i);
      allow_q <= dest_r0_i;
      ind_q   <= ind_i;
    end
  end

  ea_ptr_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept),
    .ind_i      (ind_i),
    .base_q_i   (base_q),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .busy_o     (busy_o),
    .done_o     (done),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .ptr_o      (ptr)
  );

  assign pre_idx = ind_q ? ptr : base_q;

  ea_index_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_idx (
    .base_i    (pre_idx),
    .idx_val_i (idx_q),
    .mode_i    (mode_q),
    .allow_i   (allow_q),
    .ea_o      (ea_o),
    .idx_new_o (idx_new_o),
    .idx_wr_o  (wr_want)
  );

  assign ea_valid_o = done;
  assign idx_wr_o   = done && wr_want;

endmodule

// File: rtl/paged_ea_gen_chk.sv
module paged_ea_gen_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic              rd_valid_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              ea_valid_o,
  input logic              idx_wr_o
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_o && !ea_valid_o && !idx_wr_o));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r4_low_byte_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_req_o) && $past(rd_valid_i) && rd_req_o) |->
      ((rd_addr_o[ADDR_W-1:OFF_W] == $past(rd_addr_o[ADDR_W-1:OFF_W])) &&
       (rd_addr_o[OFF_W-1:0] == $past(rd_addr_o[OFF_W-1:0]) + OFF_W'(1))));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid_o |=> !ea_valid_o);

  a_r5_no_read_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid_o |-> !rd_req_o);

  a_r7_write_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_o |-> ea_valid_o);

endmodule

bind paged_ea_gen paged_ea_gen_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .rd_addr_o  (rd_addr_o),
  .ea_valid_o (ea_valid_o),
  .idx_wr_o   (idx_wr_o)
);

// File: tb/paged_ea_gen_tb.sv
module paged_ea_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] pc_i = '0;
  logic [12:0] operand_i = '0;
  logic        rel_i = 1'b0;
  logic        ind_i = 1'b0;
  logic [1:0]  idx_mode_i = '0;
  logic        dest_r0_i = 1'b0;
  logic [7:0]  idx_val_i = '0;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        busy_o, rd_req_o, ea_valid_o, idx_wr_o;
  logic [14:0] rd_addr_o, ea_o;
  logic [7:0]  idx_new_o;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i),
    .operand_i(operand_i), .rel_i(rel_i), .ind_i(ind_i),
    .idx_mode_i(idx_mode_i), .dest_r0_i(dest_r0_i), .idx_val_i(idx_val_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .ea_valid_o(ea_valid_o),
    .ea_o(ea_o), .idx_wr_o(idx_wr_o), .idx_new_o(idx_new_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && ea_valid_o) pulses++;

  // Behavioural reference: one request, checked cycle by cycle.
  task automatic run_op(input int pc, input int opnd, input bit rel, input bit ind,
                        input int mode, input bit r0, input int iv,
                        input int hi, input int lo, input int stall,
                        input bit poke, input string tag);
    int page, off, d, base, b2, nv, ea, loaddr;
    bit wr;
    page = pc & 'h6000;
    if (rel) begin
      d = opnd & 127;
      if (d >= 64) d -= 128;
      off = ((pc & 'h1FFF) + d) & 'h1FFF;
    end else begin
      off = opnd & 'h1FFF;
    end
    base = page | off;
    loaddr = (base & 'h6000) | ((base + 1) & 'h1FFF);
    b2 = ind ? (((hi << 8) | lo) & 'h7FFF) : base;
    nv = (mode == 2) ? ((iv + 1) & 255) : (mode == 3) ? ((iv - 1) & 255) : iv;
    ea = (r0 && mode != 0) ? ((b2 & 'h6000) | (((b2 & 'h1FFF) + nv) & 'h1FFF)) : b2;
    wr = r0 && (mode >= 2);

    pc_i = pc[14:0]; operand_i = opnd[12:0]; rel_i = rel; ind_i = ind;
    idx_mode_i = mode[1:0]; dest_r0_i = r0; idx_val_i = iv[7:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_pulses++;
    if (ind) begin
      for (int s = 0; s < stall; s++) begin
        if (poke && s == 0) begin
          // R9: new start while busy must be ignored
          start_i = 1'b1; operand_i = 13'h0AAA; pc_i = 15'h7FFF; ind_i = 1'b0;
        end
        chk(rd_req_o && !ea_valid_o, {tag, " R4 hi wait"}, rd_req_o, 1);
        chk(rd_addr_o == base[14:0], {tag, " R4 hi addr"}, rd_addr_o, base);
        @(negedge clk);
        start_i = 1'b0;
      end
      chk(rd_req_o == 1'b1, {tag, " R4 hi req"}, rd_req_o, 1);
      chk(rd_addr_o == base[14:0], {tag, " R4 hi addr"}, rd_addr_o, base);
      rd_valid_i = 1'b1; rd_data_i = hi[7:0];
      @(negedge clk);
      rd_valid_i = 1'b0; rd_data_i = 8'h00;
      for (int s = 0; s < stall; s++) begin
        chk(rd_req_o && rd_addr_o == loaddr[14:0], {tag, " R4 lo wait"}, rd_addr_o, loaddr);
        @(negedge clk);
      end
      chk(rd_req_o && rd_addr_o == loaddr[14:0], {tag, " R4 lo addr"}, rd_addr_o, loaddr);
      rd_valid_i = 1'b1; rd_data_i = lo[7:0];
      @(negedge clk);
      rd_valid_i = 1'b0;
    end
    chk(ea_valid_o == 1'b1, {tag, " R2/R5 valid"}, ea_valid_o, 1);
    chk(ea_o == ea[14:0], {tag, " R3/R5/R6 ea"}, ea_o, ea);
    chk(idx_wr_o == wr, {tag, " R7/R8 idx_wr"}, idx_wr_o, wr);
    if (wr) chk(idx_new_o == nv[7:0], {tag, " R6/R7 idx_new"}, idx_new_o, nv);
    @(negedge clk);
    chk(!ea_valid_o && !busy_o, {tag, " R9 one pulse"}, ea_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_req_o && !ea_valid_o && !idx_wr_o, "R1 in reset", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rd_req_o && !ea_valid_o && !idx_wr_o, "R1 after reset", busy_o, 0);

    run_op('h4123, 'h1ABC, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 abs");
    run_op('h0010, 'h1FFF, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 abs top");
    run_op('h2050, 'h0025, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R3 rel pos");
    run_op('h2001, 'h007D, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R3 rel wrap neg");
    run_op('h7FF0, 'h003F, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 rel wrap pos");
    run_op('h6100, 'h0040, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R3 rel -64");
    run_op('h0100, 'h0300, 0, 1, 0, 1, 0, 'h5A, 'h34, 0, 0, "R4 ind");
    run_op('h2000, 'h1FFF, 0, 1, 0, 1, 0, 'hC1, 'h22, 2, 0, "R4 ind page edge");
    run_op('h0000, 'h0100, 0, 0, 1, 1, 'hF0, 0, 0, 0, 0, "R6 add");
    run_op('h6000, 'h1F80, 0, 0, 1, 1, 'hA0, 0, 0, 0, 0, "R6 add wrap");
    run_op('h2000, 'h0010, 0, 0, 2, 1, 'hFF, 0, 0, 0, 0, "R6 inc wrap");
    run_op('h4000, 'h0010, 0, 0, 3, 1, 'h00, 0, 0, 0, 0, "R6 dec wrap");
    run_op('h0000, 'h0200, 0, 1, 2, 1, 'h10, 'h3F, 'hF8, 1, 0, "R6 ind then idx");
    run_op('h0000, 'h0200, 0, 0, 3, 0, 'h10, 0, 0, 0, 0, "R8 no r0 dec");
    run_op('h0000, 'h0200, 0, 1, 1, 0, 'h10, 'h12, 'h34, 0, 0, "R8 no r0 add");
    run_op('h2400, 'h0444, 0, 1, 0, 1, 0, 'h01, 'h02, 3, 1, "R9 busy start");

    // R10: stray read-valid while idle does nothing
    rd_valid_i = 1'b1; rd_data_i = 8'hEE;
    @(negedge clk);
    chk(!busy_o && !ea_valid_o && !rd_req_o, "R10 stray valid", busy_o, 0);
    rd_valid_i = 1'b0;
    run_op('h0000, 'h0123, 0, 1, 0, 1, 0, 'h44, 'h55, 0, 0, "R10 after stray");

    repeat (3) @(negedge clk);
    chk(pulses == exp_pulses, "R9 pulse count", pulses, exp_pulses);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule